// File: doc/BRIEF.md
# Serial Bus Hold Controller

This block lets a serial memory interface pause a transaction part-way through and later continue it without losing any progress. A host that shares the serial clock with other devices pulls the active-low hold input down. Once the pause is in effect, the block stops the shift engine from seeing clock edges or data and takes the serial output off the bus. When hold is released, the transaction picks up on the exact bit where it stopped.

The serial clock is oversampled by the system clock, which must run at least twice as fast as the serial clock. A pause can begin or end only while the serial clock is low. A hold request that arrives while the serial clock is high is recorded as pending and takes effect on the next falling edge. Hold works only in single-lane and dual-lane modes, and only when the mode-register hold-disable bit is clear. In quad mode the pin is a data lane and has no hold function. The block keeps a small shift tracker: a bit position counter, an output edge counter and a receive shift register. These make a frozen or resumed transaction visible at the ports.

Top module: `serial_hold_gate`

## Requirements
- R1: While rst_n is low, and after its release with cs_n high, paused, pause_pending, out_drive, bit_pos, out_pos and rx_shift are all 0.
- R2: With hold armed (cs_n low, io_mode not 2'b10, hold_off 0), hold_n low while sclk is low sets paused one system clock later. While paused, sclk rising edges and sdi change neither bit_pos nor rx_shift, and sclk falling edges do not advance out_pos.
- R3: With hold armed, hold_n going low while sclk is high sets pause_pending but not paused. The next sclk falling edge is still counted in out_pos and starts the pause. If hold_n returns high before that fall, no pause occurs.
- R4: A paused block stays paused while sclk is high, even if hold_n is high. Once hold_n is high and sclk is low, paused clears one system clock later, and counting resumes from the frozen values.
- R5: out_drive is 0 in the same cycle that hold_n is low while hold is armed, for the whole pause, and whenever cs_n is high. Otherwise it is 1.
- R6: In quad mode (io_mode = 2'b10), hold_n is ignored: no pause, out_drive stays 1 and counting continues.
- R7: With hold_off = 1, hold_n is ignored in every mode.
- R8: cs_n high clears a pause and zeroes bit_pos, out_pos and rx_shift one system clock later.
- R9: Each counted sclk rising edge adds the lane count to bit_pos: 1 for io_mode 2'b00 or 2'b11, 2 for 2'b01 and 4 for 2'b10. It also shifts rx_shift left by the lane count and fills the vacated low bits with sdi[lanes-1:0], keeping their order. Each counted falling edge adds 1 to out_pos.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples sclk |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock level |
| hold_n | input | 1 | Active-low hold request |
| sdi | input | 4 | Serial data lanes |
| io_mode | input | 2 | Lane mode: 00 single, 01 dual, 10 quad, 11 single |
| hold_off | input | 1 | Mode-register bit 0: 1 disables hold |
| paused | output | 1 | Pause in effect |
| pause_pending | output | 1 | Hold requested while sclk high, waiting for fall |
| out_drive | output | 1 | Serial output enable (0 means high impedance) |
| bit_pos | output | CW | Bits received in this transaction |
| out_pos | output | CW | Output-update edges counted in this transaction |
| rx_shift | output | SW | Receive shift register |

## Verification
The hardest situation to reach is a hold request that arrives while sclk is high, followed by a release during the pause while sclk is still high. In that case the falling edge that starts the pause must be counted, and the falling edge that ends it must not. The stimulus steps sclk and hold_n one system clock apart, so each ordering is covered on its own. It also repeats the sequence for every lane mode with hold both enabled and disabled, so the same script shows the freeze when hold is armed and plain counting when it is not. A chip-select abort issued during an active pause finishes each pass.

// File: rtl/shg_pkg.sv
package shg_pkg;

  typedef enum logic [1:0] {
    LANE_X1  = 2'b00,
    LANE_X2  = 2'b01,
    LANE_X4  = 2'b10,
    LANE_RSV = 2'b11
  } lane_mode_e;

  typedef enum logic [1:0] {
    PH_RUN  = 2'b00,
    PH_PEND = 2'b01,
    PH_HELD = 2'b10
  } hold_phase_e;

  function automatic logic [2:0] lane_count(input lane_mode_e m);
    unique case (m)
      LANE_X2: lane_count = 3'd2;
      LANE_X4: lane_count = 3'd4;
      default: lane_count = 3'd1;
    endcase
  endfunction

  function automatic logic hold_capable(input lane_mode_e m);
    hold_capable = (m != LANE_X4);
  endfunction

endpackage

// File: rtl/shg_edge_det.sv
module shg_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic rise,
  output logic fall,
  output logic sclk_low
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign rise     = sclk & ~sclk_q;
  assign fall     = ~sclk & sclk_q;
  assign sclk_low = ~sclk;
endmodule

// File: rtl/shg_pause_fsm.sv
module shg_pause_fsm
  import shg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       hold_n,
  input  logic       hold_off,
  input  lane_mode_e mode,
  input  logic       sclk_low,
  input  logic       fall,
  output logic       gate_open,
  output logic       paused,
  output logic       pending,
  output logic       out_drive
);
  hold_phase_e ph, ph_nxt;
  logic        armed;

  assign armed = ~cs_n & hold_capable(mode) & ~hold_off;

  always_comb begin
    ph_nxt = ph;
    unique case (ph)
      PH_RUN:  if (armed && !hold_n) ph_nxt = sclk_low ? PH_HELD : PH_PEND;
      PH_PEND: begin
        if (!armed || hold_n) ph_nxt = PH_RUN;
        else if (fall)        ph_nxt = PH_HELD;
      end
      PH_HELD: if (!armed || (hold_n && sclk_low)) ph_nxt = PH_RUN;
      default: ph_nxt = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_RUN;
    else        ph <= ph_nxt;
  end

  assign gate_open = (ph != PH_HELD);
  assign paused    = (ph == PH_HELD);
  assign pending   = (ph == PH_PEND);
  assign out_drive = ~cs_n & gate_open & ~(armed & ~hold_n);

  AST_LOW_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_RUN && armed && !hold_n && sclk_low) |=> (ph == PH_HELD)); // R2
  AST_HIGH_DEFERS: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_RUN && armed && !hold_n && !sclk_low) |=> (ph == PH_PEND)); // R3
  AST_NO_HIGH_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_HELD && armed && !sclk_low) |=> (ph == PH_HELD)); // R4
  AST_QUIET_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> !out_drive); // R5
  AST_QUAD_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LANE_X4) |=> (ph == PH_RUN)); // R6
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    hold_off |=> (ph == PH_RUN)); // R7
  AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (ph == PH_RUN)); // R8
endmodule

// File: rtl/shg_shift_track.sv
module shg_shift_track
  import shg_pkg::*;
#(
  parameter int SW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          rise_ok,
  input  logic          fall_ok,
  input  lane_mode_e    mode,
  input  logic [3:0]    sdi,
  output logic [CW-1:0] bit_pos,
  output logic [CW-1:0] out_pos,
  output logic [SW-1:0] rx_shift
);
  function automatic logic [SW-1:0] shift_merge(input logic [SW-1:0] cur,
                                                input logic [3:0] d,
                                                input lane_mode_e m);
    unique case (m)
      LANE_X2: shift_merge = {cur[SW-3:0], d[1:0]};
      LANE_X4: shift_merge = {cur[SW-5:0], d};
      default: shift_merge = {cur[SW-2:0], d[0]};
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_pos  <= '0;
      out_pos  <= '0;
      rx_shift <= '0;
    end else if (clear) begin
      bit_pos  <= '0;
      out_pos  <= '0;
      rx_shift <= '0;
    end else begin
      if (rise_ok) begin
        bit_pos  <= bit_pos + CW'(lane_count(mode));
        rx_shift <= shift_merge(rx_shift, sdi, mode);
      end
      if (fall_ok) out_pos <= out_pos + 1'b1;
    end
  end

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (bit_pos == '0 && out_pos == '0 && rx_shift == '0)); // R8
endmodule

// File: rtl/serial_hold_gate.sv
module serial_hold_gate
  import shg_pkg::*;
#(
  parameter int SW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          hold_n,
  input  logic [3:0]    sdi,
  input  logic [1:0]    io_mode,
  input  logic          hold_off,
  output logic          paused,
  output logic          pause_pending,
  output logic          out_drive,
  output logic [CW-1:0] bit_pos,
  output logic [CW-1:0] out_pos,
  output logic [SW-1:0] rx_shift
);
  lane_mode_e mode;
  logic       rise, fall, sclk_low, gate_open;
  logic       rise_ok, fall_ok;

  assign mode = lane_mode_e'(io_mode);

  shg_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .sclk(sclk),
    .rise(rise), .fall(fall), .sclk_low(sclk_low)
  );

  shg_pause_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n),
    .hold_off(hold_off), .mode(mode), .sclk_low(sclk_low), .fall(fall),
    .gate_open(gate_open), .paused(paused), .pending(pause_pending),
    .out_drive(out_drive)
  );

  assign rise_ok = rise & gate_open & ~cs_n;
  assign fall_ok = fall & gate_open & ~cs_n;

  shg_shift_track #(.SW(SW), .CW(CW)) u_track (
    .clk(clk), .rst_n(rst_n), .clear(cs_n), .rise_ok(rise_ok),
    .fall_ok(fall_ok), .mode(mode), .sdi(sdi),
    .bit_pos(bit_pos), .out_pos(out_pos), .rx_shift(rx_shift)
  );

  AST_FROZEN_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && !cs_n) |=> ($stable(rx_shift) && $stable(bit_pos) && $stable(out_pos))); // R2
endmodule

// File: tb/serial_hold_gate_bench.sv
`timescale 1ns/1ps
module serial_hold_gate_bench;
  localparam int SW = 16;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, hold_n, hold_off;
  logic [3:0] sdi;
  logic [1:0] io_mode;
  logic paused, pause_pending, out_drive;
  logic [CW-1:0] bit_pos, out_pos;
  logic [SW-1:0] rx_shift;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [CW-1:0] exp_pos, exp_fall;
  logic [SW-1:0] exp_shift;

  always #2 clk = ~clk;

  serial_hold_gate #(.SW(SW), .CW(CW)) u_serial_hold_gate (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .hold_n(hold_n),
    .sdi(sdi), .io_mode(io_mode), .hold_off(hold_off),
    .paused(paused), .pause_pending(pause_pending), .out_drive(out_drive),
    .bit_pos(bit_pos), .out_pos(out_pos), .rx_shift(rx_shift)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lanes_of(input logic [1:0] m);
    if (m == 2'b10) return 4;
    if (m == 2'b01) return 2;
    return 1;
  endfunction

  function automatic logic [SW-1:0] pushed(input logic [SW-1:0] cur,
                                           input logic [3:0] d, input int n);
    int mask;
    mask = (1 << n) - 1;
    return SW'((int'(cur) << n) | (int'(d) & mask));
  endfunction

  task automatic cmp_all(input string tag);
    chk({tag, " bit_pos"}, bit_pos, exp_pos);
    chk({tag, " rx_shift"}, rx_shift, exp_shift);
    chk({tag, " out_pos"}, out_pos, exp_fall);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // One full sclk cycle; live_r/live_f say whether the bench expects each edge counted
  task automatic pulse(input logic [3:0] d, input bit live_r, input bit live_f);
    sdi = d;
    sclk = 1'b1;
    tick();
    if (live_r) begin
      exp_pos   = exp_pos + CW'(lanes_of(io_mode));
      exp_shift = pushed(exp_shift, d, lanes_of(io_mode));
    end
    sclk = 1'b0;
    tick();
    if (live_f) exp_fall = exp_fall + 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; hold_n = 1'b1;
    hold_off = 1'b0; sdi = 4'h0; io_mode = 2'b00;
    repeat (3) tick();
    chk("R1 paused in reset", paused, 0);
    chk("R1 out_drive in reset", out_drive, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 paused", paused, 0);
    chk("R1 pending", pause_pending, 0);
    chk("R1 out_drive", out_drive, 0);
    chk("R1 bit_pos", bit_pos, 0);
    chk("R1 out_pos", out_pos, 0);
    chk("R1 rx_shift", rx_shift, 0);

    for (int m = 0; m < 4; m++) begin
      for (int off = 0; off < 2; off++) begin
        bit eff;
        string tg;
        eff = (m != 2) && (off == 0);
        tg  = eff ? "R2" : ((m == 2 && off == 0) ? "R6" : "R7");
        io_mode = 2'(m); hold_off = off[0];
        exp_pos = '0; exp_fall = '0; exp_shift = '0;
        cs_n = 1'b0; hold_n = 1'b1; sclk = 1'b0;
        tick();
        chk("R5 drive when selected", out_drive, 1);

        for (int k = 0; k < 3; k++) pulse(4'((m * 7 + k * 5 + off * 3) & 15), 1, 1);
        cmp_all("R9 lanes");

        // Hold low with sclk low
        hold_n = 1'b0;
        #1 chk("R5 hold forces high-Z", out_drive, eff ? 0 : 1);
        tick();
        chk({tg, " pause from low sclk"}, paused, eff);
        pulse(4'hA, !eff, !eff);
        pulse(4'h5, !eff, !eff);
        cmp_all({tg, " frozen counters"});
        chk("R5 drive during pause", out_drive, eff ? 0 : 1);

        // Release while sclk high: must stay paused
        sclk = 1'b1; tick();
        if (!eff) begin
          exp_pos   = exp_pos + CW'(lanes_of(io_mode));
          exp_shift = pushed(exp_shift, sdi, lanes_of(io_mode));
        end
        hold_n = 1'b1; tick();
        chk("R4 no resume while sclk high", paused, eff);
        chk("R5 drive while still held", out_drive, eff ? 0 : 1);
        sclk = 1'b0; tick();
        if (!eff) exp_fall = exp_fall + 1'b1;
        chk("R4 resume at low sclk", paused, 0);
        chk("R5 drive after resume", out_drive, 1);
        cmp_all("R4 resume point");

        // Hold low while sclk high: deferred
        sclk = 1'b1; sdi = 4'h3; tick();
        exp_pos   = exp_pos + CW'(lanes_of(io_mode));
        exp_shift = pushed(exp_shift, 4'h3, lanes_of(io_mode));
        hold_n = 1'b0; tick();
        chk("R3 not paused while sclk high", paused, 0);
        chk("R3 pending flag", pause_pending, eff);
        chk("R5 drive off on pending hold", out_drive, eff ? 0 : 1);
        sclk = 1'b0; tick();
        exp_fall = exp_fall + 1'b1;
        chk("R3 pause at falling edge", paused, eff);
        cmp_all("R3 fall still counted");
        hold_n = 1'b1; tick();
        chk("R4 released", paused, 0);

        // Hold pulse that ends before the fall
        sclk = 1'b1; sdi = 4'hC; tick();
        exp_pos   = exp_pos + CW'(lanes_of(io_mode));
        exp_shift = pushed(exp_shift, 4'hC, lanes_of(io_mode));
        hold_n = 1'b0; tick();
        hold_n = 1'b1; tick();
        sclk = 1'b0; tick();
        exp_fall = exp_fall + 1'b1;
        chk("R3 cancelled hold no pause", paused, 0);

        pulse(4'h9, 1, 1);
        pulse(4'h6, 1, 1);
        cmp_all("R9 continue after pauses");

        // Abort during pause
        hold_n = 1'b0; tick();
        chk({tg, " paused before abort"}, paused, eff);
        cs_n = 1'b1; hold_n = 1'b1;
        #1 chk("R5 deselected high-Z", out_drive, 0);
        tick();
        chk("R8 pause cleared", paused, 0);
        chk("R8 bit_pos cleared", bit_pos, 0);
        chk("R8 out_pos cleared", out_pos, 0);
        chk("R8 rx_shift cleared", rx_shift, 0);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule